// File: doc/BRIEF.md
# Instruction Pre-Decoder

This block sits between an instruction fetch stream and the execute stage of a 32-bit processor with variable-length instructions. It takes one byte per handshake, low byte first. It first assembles a 16-bit control word and splits it into its fields. It then collects as many operand bytes as the opcode and the operand types call for. Finally it presents one decoded instruction, held in a register, until the downstream stage takes it.

Each instruction has a two-byte header. The header may be followed by a source operand, or by a source operand and then a target operand. The width of each operand depends on its type and on the operation size. The condition field is tested against the zero and carry flags. The result is an execute-enable bit, and that bit is forced low for any malformed instruction. The block does not execute the operation, does not dereference pointer operands and does not update the flags.

The block runs a five-state machine:
- `S_CW_LO` waits for the control word low byte.
- `S_CW_HI` waits for the high byte. From there the next state is `S_EMIT` when the header is malformed or the opcode takes no operands, and `S_SRC` otherwise.
- `S_SRC` collects the source bytes. After the last one it moves to `S_TGT` for two-operand opcodes and to `S_EMIT` otherwise.
- `S_TGT` collects the target bytes and then moves to `S_EMIT`.
- `S_EMIT` presents the result and returns to `S_CW_LO` once `out_ready` is seen.

Top module: `insn_predecode`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The first accepted byte is the control word low half and the second is the high half. Within the word:
  - bits 1:0 are the source type and bits 3:2 the target type;
  - bits 6:4 are the condition and bit 7 is reserved;
  - bits 13:8 are the opcode and bits 15:14 the size.
  The source type, target type, condition, opcode and size appear unchanged on the output ports.
- R3: Each used operand takes a number of bytes set by its type and the size:
  - type 0 (register) and type 1 (register pointer) take 1 byte;
  - type 2 (immediate) takes 1, 2 or 4 bytes for size 0, 1 or 2;
  - type 3 (immediate pointer) takes 4 bytes.
  Source bytes come before target bytes. Each value is assembled little-endian and zero-extended to 32 bits.
- R4: Each opcode takes no operands, a source only, or a source and a target:
  - no operands: 0x00, 0x0C, 0x0D, 0x10, 0x1C, 0x1D, 0x20, 0x2A, 0x3A;
  - source only: 0x08–0x0A, 0x11, 0x18–0x1A, 0x28, 0x29, 0x2C, 0x2D, 0x31, 0x33, 0x3D;
  - source and target: 0x01–0x07, 0x0B, 0x13–0x17, 0x1B, 0x21–0x27, 0x32, 0x34, 0x35, 0x39.
  An unused operand takes zero bytes, its type bits have no effect, and its value output is 0.
- R5: `out_len` equals 2 plus the byte counts of the used operands.
- R6: `out_exec` is 1 only for a valid instruction whose condition passes. The flags are taken in the cycle the last byte of the instruction is accepted. The condition codes pass as follows:
  - 0 always passes;
  - 1 passes when Z is set and 2 when Z is clear;
  - 3 passes when C is set and 4 when C is clear;
  - 5 passes when Z and C are both clear;
  - 6 passes when Z or C is set.
  Later flag changes do not alter a presented result.
- R7: A malformed header raises `out_invalid`, clears `out_exec` and gives `out_len` = 2 with both values 0. The output appears right after the high byte. A header is malformed when any of these holds:
  - the condition is 7;
  - the size is 3;
  - bit 7 is set;
  - the opcode is not listed in R4.
- R8: A register or register-pointer operand byte above 34 raises `out_invalid` and clears `out_exec`. Collection and the length are unaffected.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output holds and `in_ready` is 0, so no input byte is consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch byte available |
| in_byte | input | 8 | Fetch byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| out_valid | output | 1 | Decoded instruction presented |
| out_ready | input | 1 | Downstream takes the decoded instruction |
| out_src_kind | output | 2 | Source operand type |
| out_tgt_kind | output | 2 | Target operand type |
| out_cond | output | 3 | Condition field |
| out_opcode | output | 6 | Opcode field |
| out_size | output | 2 | Operation size field |
| out_src_val | output | 32 | Source operand value |
| out_tgt_val | output | 32 | Target operand value |
| out_len | output | 4 | Instruction length in bytes |
| out_exec | output | 1 | Condition passed and instruction valid |
| out_invalid | output | 1 | Malformed instruction |

## Verification
The assertions assume that the consumer drops `out_ready` only while the result is presented. They also assume that `in_byte` matters only when it is accepted. Beyond that, they take nothing about the fetch stream. The stimulus sends whole instructions and holds the flags steady from the first byte to the last. It deliberately offers junk bytes and toggles the flags while a result is held. Random opcodes, sizes, conditions and register numbers are mostly drawn from their legal ranges, with a fixed share of malformed values mixed in.

// File: rtl/predec_pkg.sv
package predec_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OPK_REG    = 2'd0,
        OPK_REGPTR = 2'd1,
        OPK_IMM    = 2'd2,
        OPK_IMMPTR = 2'd3
    } opnd_kind_t;

    typedef enum logic [1:0] {
        AR_NONE = 2'd0,
        AR_SRC  = 2'd1,
        AR_BOTH = 2'd2,
        AR_BAD  = 2'd3
    } arity_t;

    typedef enum logic [2:0] {
        S_CW_LO, S_CW_HI, S_SRC, S_TGT, S_EMIT
    } state_t;

    // control word view, MSB first (R2 bit positions)
    typedef struct packed {
        logic [1:0] size;
        logic [5:0] opcode;
        logic       rsvd;
        logic [2:0] cond;
        logic [1:0] tgt;
        logic [1:0] src;
    } ctrl_t;

    // R3: byte count of one operand
    function automatic logic [2:0] opnd_bytes(input logic [1:0] kind, input logic [1:0] size);
        logic [2:0] n;
        unique case (opnd_kind_t'(kind))
            OPK_REG, OPK_REGPTR: n = 3'd1;
            OPK_IMMPTR:          n = 3'd4;
            default:             n = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/predec_arity.sv
module predec_arity
    import predec_pkg::*;
(
    input  logic [5:0] opcode,
    output arity_t     arity
);
    // R4 operand classes
    always_comb begin
        case (opcode) inside
            6'h00, 6'h0C, 6'h0D, 6'h10, 6'h1C, 6'h1D, 6'h20, 6'h2A, 6'h3A:
                arity = AR_NONE;
            [6'h08:6'h0A], 6'h11, [6'h18:6'h1A], 6'h28, 6'h29, 6'h2C, 6'h2D,
            6'h31, 6'h33, 6'h3D:
                arity = AR_SRC;
            [6'h01:6'h07], 6'h0B, [6'h13:6'h17], 6'h1B, [6'h21:6'h27],
            6'h32, 6'h34, 6'h35, 6'h39:
                arity = AR_BOTH;
            default:
                arity = AR_BAD;
        endcase
    end
endmodule

// File: rtl/predec_cond.sv
module predec_cond (
    input  logic [2:0] cond,
    input  logic       flag_z,
    input  logic       flag_c,
    output logic       pass,
    output logic       reserved
);
    // R6 condition table, R7 reserved code
    always_comb begin
        reserved = 1'b0;
        unique case (cond)
            3'd0: pass = 1'b1;
            3'd1: pass = flag_z;
            3'd2: pass = !flag_z;
            3'd3: pass = flag_c;
            3'd4: pass = !flag_c;
            3'd5: pass = !flag_z && !flag_c;
            3'd6: pass = flag_z || flag_c;
            default: begin
                pass     = 1'b0;
                reserved = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
    import predec_pkg::*;
#(
    parameter int VAL_W   = 32,
    parameter int LEN_W   = 4,
    parameter int MAX_REG = 34
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             flag_z,
    input  logic             flag_c,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_src_kind,
    output logic [1:0]       out_tgt_kind,
    output logic [2:0]       out_cond,
    output logic [5:0]       out_opcode,
    output logic [1:0]       out_size,
    output logic [VAL_W-1:0] out_src_val,
    output logic [VAL_W-1:0] out_tgt_val,
    output logic [LEN_W-1:0] out_len,
    output logic             out_exec,
    output logic             out_invalid
);
    localparam int NBYTES = VAL_W / BYTE_W;
    localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    state_t            state, state_nx;
    logic [7:0]        cw_lo;
    ctrl_t             ctrl, view;
    logic [CNT_W-1:0]  cnt;
    logic [VAL_W-1:0]  src_val, tgt_val;
    logic              bad_reg, exec_r;

    arity_t            arity;
    logic              pass, cond_rsvd, hdr_bad, take, last, reg_bad_now;
    logic [2:0]        src_n, tgt_n, cur_n;
    logic [1:0]        cur_kind;

    // while the high byte arrives the header is judged from the wire
    assign view = (state == S_CW_HI) ? ctrl_t'({in_byte, cw_lo}) : ctrl;

    predec_arity u_arity (.opcode(view.opcode), .arity(arity));
    predec_cond  u_cond  (.cond(view.cond), .flag_z(flag_z), .flag_c(flag_c),
                          .pass(pass), .reserved(cond_rsvd));

    // R7 malformed header
    assign hdr_bad  = view.rsvd || (view.size == 2'd3) || cond_rsvd || (arity == AR_BAD);
    assign src_n    = opnd_bytes(view.src, view.size);
    assign tgt_n    = opnd_bytes(view.tgt, view.size);
    assign cur_kind = (state == S_TGT) ? view.tgt : view.src;
    assign cur_n    = (state == S_TGT) ? tgt_n : src_n;
    assign take     = in_valid && in_ready;
    assign last     = ({{(3-CNT_W){1'b0}}, cnt} == cur_n - 3'd1);
    // R8 register number range
    assign reg_bad_now = (cur_kind == OPK_REG || cur_kind == OPK_REGPTR) &&
                         (in_byte > 8'(MAX_REG));

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CW_LO: if (take) state_nx = S_CW_HI;
            S_CW_HI: if (take) state_nx = (hdr_bad || arity == AR_NONE) ? S_EMIT : S_SRC;
            S_SRC:   if (take && last) state_nx = (arity == AR_BOTH) ? S_TGT : S_EMIT;
            S_TGT:   if (take && last) state_nx = S_EMIT;
            S_EMIT:  if (out_ready) state_nx = S_CW_LO;
            default: state_nx = S_CW_LO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_CW_LO;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_lo   <= '0;
            ctrl    <= '0;
            cnt     <= '0;
            src_val <= '0;
            tgt_val <= '0;
            bad_reg <= 1'b0;
            exec_r  <= 1'b0;
        end else if (take) begin
            unique case (state)
                S_CW_LO: cw_lo <= in_byte;
                S_CW_HI: begin
                    ctrl    <= view;
                    cnt     <= '0;
                    src_val <= '0;
                    tgt_val <= '0;
                    bad_reg <= 1'b0;
                    exec_r  <= pass && !hdr_bad;
                end
                S_SRC, S_TGT: begin
                    for (int i = 0; i < NBYTES; i++) begin
                        if (cnt == CNT_W'(i)) begin
                            if (state == S_SRC) src_val[i*BYTE_W +: BYTE_W] <= in_byte;
                            else                tgt_val[i*BYTE_W +: BYTE_W] <= in_byte;
                        end
                    end
                    cnt     <= last ? '0 : cnt + 1'b1;
                    bad_reg <= bad_reg || reg_bad_now;
                    // R6: flags of the final accepted byte decide
                    exec_r  <= pass && !bad_reg && !reg_bad_now;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        in_ready     = (state != S_EMIT);
        out_valid    = (state == S_EMIT);
        out_src_kind = ctrl.src;
        out_tgt_kind = ctrl.tgt;
        out_cond     = ctrl.cond;
        out_opcode   = ctrl.opcode;
        out_size     = ctrl.size;
        out_src_val  = src_val;
        out_tgt_val  = tgt_val;
        out_exec     = exec_r;
        out_invalid  = hdr_bad || bad_reg;
        // R5 length
        out_len      = LEN_W'(2);
        if (!hdr_bad && arity != AR_NONE) out_len = out_len + LEN_W'(src_n);
        if (!hdr_bad && arity == AR_BOTH) out_len = out_len + LEN_W'(tgt_n);
    end
endmodule

// File: rtl/predec_chk.sv
module predec_chk #(
    parameter int VAL_W = 32,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [2:0]       out_cond,
    input logic [1:0]       out_size,
    input logic [VAL_W-1:0] out_src_val,
    input logic [VAL_W-1:0] out_tgt_val,
    input logic [LEN_W-1:0] out_len,
    input logic             out_exec,
    input logic             out_invalid
);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_src_val) && $stable(out_tgt_val)
                                   && $stable(out_len) && $stable(out_exec) && $stable(out_invalid));
    // R9
    no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(2)) && (out_len <= LEN_W'(10)));
    // R6
    inv_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> !out_exec);
    // R7
    rsvd_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_size == 2'd3 || out_cond == 3'd7) |-> out_invalid && out_len == LEN_W'(2));
    // R4
    nooperand_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len == LEN_W'(2) |-> out_src_val == '0 && out_tgt_val == '0);
endmodule

bind insn_predecode predec_chk #(.VAL_W(VAL_W), .LEN_W(LEN_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_cond(out_cond), .out_size(out_size),
    .out_src_val(out_src_val), .out_tgt_val(out_tgt_val), .out_len(out_len),
    .out_exec(out_exec), .out_invalid(out_invalid)
);

// File: tb/test_insn_predecode.sv
module test_insn_predecode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        flag_z = 1'b0, flag_c = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_src_kind, out_tgt_kind, out_size;
    logic [2:0]  out_cond;
    logic [5:0]  out_opcode;
    logic [31:0] out_src_val, out_tgt_val;
    logic [3:0]  out_len;
    logic        out_exec, out_invalid;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    insn_predecode i_insn_predecode (.*);

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int b_arity(input int op);
        if (op inside {0, 12, 13, 16, 28, 29, 32, 42, 58}) return 0;
        if (op inside {8, 9, 10, 17, 24, 25, 26, 40, 41, 44, 45, 49, 51, 61}) return 1;
        if ((op >= 1 && op <= 7) || (op >= 19 && op <= 23) || (op >= 33 && op <= 39) ||
            op inside {11, 27, 50, 52, 53, 57}) return 2;
        return -1;
    endfunction

    function automatic int b_cnt(input int kind, input int sz);
        if (kind <= 1) return 1;
        if (kind == 3) return 4;
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    function automatic bit b_cond(input int cc, input bit z, input bit c);
        case (cc)
            0: return 1'b1;
            1: return z;
            2: return !z;
            3: return c;
            4: return !c;
            5: return !(z || c);
            6: return z || c;
            default: return 1'b0;
        endcase
    endfunction

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic run_insn(input int st, input int tt, input int cc, input int op, input int sz,
                            input bit rs, input logic [31:0] sv, input logic [31:0] tv,
                            input bit z, input bit c);
        int a, ns, nt, len;
        bit hdrbad, regbad, ex;
        logic [31:0] esv, etv;
        a      = b_arity(op);
        hdrbad = rs || sz == 3 || cc == 7 || a < 0;
        regbad = 1'b0;
        esv = '0; etv = '0; len = 2;
        flag_z = z; flag_c = c;
        push_byte({rs, 3'(cc), 2'(tt), 2'(st)});
        push_byte({2'(sz), 6'(op)});
        if (!hdrbad && a >= 1) begin
            ns = b_cnt(st, sz);
            for (int i = 0; i < ns; i++) begin
                push_byte(sv[i*8 +: 8]);
                esv[i*8 +: 8] = sv[i*8 +: 8];
            end
            len += ns;
            if (st <= 1 && sv[7:0] > 8'd34) regbad = 1'b1;
        end
        if (!hdrbad && a == 2) begin
            nt = b_cnt(tt, sz);
            for (int i = 0; i < nt; i++) begin
                push_byte(tv[i*8 +: 8]);
                etv[i*8 +: 8] = tv[i*8 +: 8];
            end
            len += nt;
            if (tt <= 1 && tv[7:0] > 8'd34) regbad = 1'b1;
        end
        ex = !hdrbad && !regbad && b_cond(cc, z, c);
        @(negedge clk);
        while (!out_valid) @(negedge clk);
        check("R2", "fields", {out_src_kind, out_tgt_kind, out_cond, out_opcode, out_size},
              {2'(st), 2'(tt), 3'(cc), 6'(op), 2'(sz)});
        check("R3", "src_val", out_src_val, esv);
        check(a < 2 ? "R4" : "R3", "tgt_val", out_tgt_val, etv);
        check("R5", "len", out_len, len);
        check(hdrbad ? "R7" : "R8", "invalid", out_invalid, hdrbad || regbad);
        check("R6", "exec", out_exec, ex);
        // hold with junk offered and flags flipped
        in_valid = 1'b1; in_byte = 8'hA5;
        flag_z = !z; flag_c = !c;
        @(negedge clk);
        check("R9", "in_ready held", in_ready, 0);
        check("R9", "valid held", out_valid, 1);
        check("R6", "exec after flag change", out_exec, ex);
        check("R9", "len held", out_len, len);
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "out_valid at reset", out_valid, 0);
        check("R1", "in_ready at reset", in_ready, 1);

        // directed corners
        run_insn(2, 0, 0, 'h17, 1, 0, 32'h0000BEEF, 32'd5, 0, 0);   // mov.16 imm -> reg
        run_insn(3, 3, 0, 'h00, 2, 0, 32'h0, 32'h0, 0, 0);          // nop, types ignored R4
        run_insn(3, 2, 0, 'h08, 2, 0, 32'h12345678, 32'hFFFF, 0, 0);// jmp imm ptr, no target R4
        run_insn(2, 2, 1, 'h01, 2, 0, 32'hDEADBEEF, 32'h01020304, 1, 0);
        run_insn(0, 0, 7, 'h01, 2, 0, 32'd1, 32'd2, 0, 0);          // R7 cond 7
        run_insn(0, 0, 0, 'h01, 3, 0, 32'd1, 32'd2, 0, 0);          // R7 size 3
        run_insn(0, 0, 0, 'h01, 0, 1, 32'd1, 32'd2, 0, 0);          // R7 bit 7
        run_insn(0, 0, 0, 'h0E, 0, 0, 32'd1, 32'd2, 0, 0);          // R7 undefined
        run_insn(0, 1, 0, 'h17, 0, 0, 32'd35, 32'd34, 0, 0);        // R8 reg 35
        run_insn(1, 0, 0, 'h17, 2, 0, 32'd34, 32'd0, 0, 0);         // reg 34 valid
        for (int cc = 0; cc < 7; cc++)
            for (int f = 0; f < 4; f++)
                run_insn(0, 0, cc, 'h00, 0, 0, 0, 0, f[0], f[1]);     // R6 table

        // constrained random
        for (int n = 0; n < 300; n++) begin
            int op, sz, cc, st, tt;
            bit rs;
            logic [31:0] sv, tv;
            op = $urandom % 64;
            for (int k = 0; k < 6 && b_arity(op) < 0; k++) op = $urandom % 64;
            sz = ($urandom % 8 == 0) ? 3 : $urandom % 3;
            cc = ($urandom % 10 == 0) ? 7 : $urandom % 7;
            rs = ($urandom % 16 == 0);
            st = $urandom % 4;
            tt = $urandom % 4;
            sv = $urandom;
            tv = $urandom;
            if (st <= 1) sv[7:0] = ($urandom % 8 == 0) ? 8'(35 + $urandom % 221) : 8'($urandom % 35);
            if (tt <= 1) tv[7:0] = ($urandom % 8 == 0) ? 8'(35 + $urandom % 221) : 8'($urandom % 35);
            run_insn(st, tt, cc, op, sz, rs, sv, tv, 1'($urandom), 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule